// File: doc/BRIEF.md
# DDR Burst SRAM Command Controller

This block models a synchronous burst SRAM that moves two data words per clock cycle. The words travel on two lanes. The rising-phase lane carries the even beat of a pair and the falling-phase lane carries the odd beat. A small internal array stands in for the memory. On each rising clock edge the block samples an address and three active-low strobes. From these it starts a read or write burst, extends the current burst, or idles.

A single command moves 2 words in one cycle. A double command moves 4 words over two consecutive cycles. A continue command adds 2 more words at the next burst position. Only the two low address bits step through the burst. A strap pin chooses linear order or interleaved order. For reads, the block drives a registered output enable for the external tri-state data bus. That enable is only raised when the output-enable input was low with the read.

Top module: `ddr_burst_sram`

## Requirements
- R1: A load (`load_n`=0) with `rw_n`=1 and `len_n`=1 is a single read. One cycle after the command edge, `dq_oe` is 1 for one cycle and the lanes show the words at beat positions 0 and 1. Whenever `dq_oe` is 0, both read lanes read 0.
- R2: A load with `len_n`=0 is a double burst of 4 beats. Beats 0 and 1 use the command cycle and beats 2 and 3 use the next cycle. All strobes and the address sampled in that second cycle are ignored.
- R3: With `order_sel`=0 the beat address low bits are (start + beat) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With `order_sel`=1 the beat address low bits are start XOR beat. For example, a start of 10 gives 10, 11, 00, 01.
- R5: A continue (`load_n`=1, `rw_n`=1) repeats the last operation on the next two beat positions. Repeated continues wrap within the same 4-word block. The upper address bits stay fixed for the whole burst.
- R6: A write stores `wdata_r` and `wdata_f` as full words into beats 0 and 1 on the command edge, and into beats 2 and 3 on the next edge for a double write. A write never raises `dq_oe`. A read issued in the cycle right after a write returns the new data.
- R7: A NOP (`load_n`=1, `rw_n`=0) gives `dq_oe`=0 in the following cycle. A continue issued after a NOP has no effect.
- R8: A read sampled with `oe_n`=1 leaves `dq_oe` at 0 and both lanes at 0 in the following cycle.
- R9: After reset, `dq_oe` is 0 and the lanes are 0, and no burst is open, so a continue has no effect. Reset in the middle of a burst clears `dq_oe` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low address load strobe |
| rw_n | input | 1 | 1 = read, 0 = write; with `load_n`=1: 1 = continue, 0 = NOP |
| len_n | input | 1 | 1 = single (2 beats), 0 = double (4 beats) |
| addr | input | ADDR_W | Word address; low two bits are the burst start |
| oe_n | input | 1 | Active-low output enable for read data |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| wdata_r | input | DATA_W | Write word, even beat |
| wdata_f | input | DATA_W | Write word, odd beat |
| rdata_r | output | DATA_W | Read word, even beat |
| rdata_f | output | DATA_W | Read word, odd beat |
| dq_oe | output | 1 | Registered data-bus drive enable |

## Verification
The assertions check on every cycle that a high `oe_n`, a NOP or a write command is never followed by a driven bus. They also check that the second cycle of a double burst only ever follows a double load. Some behaviours can only be shown by the bench's scenarios, because they depend on memory contents. These are the beat address order under both straps, the wrap of repeated continues, the strobes ignored during a second cycle, and read-after-write data.

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rw_n,
  input  logic              len_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic              order_sel,
  input  logic [DATA_W-1:0] wdata_r,
  input  logic [DATA_W-1:0] wdata_f,
  output logic [DATA_W-1:0] rdata_r,
  output logic [DATA_W-1:0] rdata_f,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              busy2_q, has_op_q, op_rd_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        nxt_q;
  logic [DATA_W-1:0] q_r, q_f;

  function automatic logic [1:0] beat_lo(input logic ilv, input logic [1:0] s, input logic [1:0] i);
    return ilv ? (s ^ i) : (s + i);
  endfunction

  wire is_load = !load_n && !busy2_q;
  wire is_cont = load_n && rw_n && !busy2_q && has_op_q;
  wire is_nop  = load_n && !rw_n && !busy2_q;
  wire act     = busy2_q || is_load || is_cont;
  wire rd      = is_load ? rw_n : op_rd_q;

  wire [ADDR_W-1:0] start = is_load ? addr : base_q;
  wire [1:0]        k     = is_load ? 2'd0 : nxt_q;
  wire [ADDR_W-1:0] a0    = {start[ADDR_W-1:2], beat_lo(order_sel, start[1:0], k)};
  wire [ADDR_W-1:0] a1    = {start[ADDR_W-1:2], beat_lo(order_sel, start[1:0], k + 2'd1)};

  always_ff @(posedge clk) begin
    if (act && !rd) begin
      mem[a0] <= wdata_r;
      mem[a1] <= wdata_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy2_q  <= 1'b0;
      has_op_q <= 1'b0;
      op_rd_q  <= 1'b0;
      base_q   <= '0;
      nxt_q    <= 2'd0;
      dq_oe    <= 1'b0;
      q_r      <= '0;
      q_f      <= '0;
    end else begin
      dq_oe <= act && rd && !oe_n;
      if (act && rd) begin
        q_r <= mem[a0];
        q_f <= mem[a1];
      end
      if (busy2_q) begin
        busy2_q <= 1'b0;
        nxt_q   <= nxt_q + 2'd2;
      end else if (is_load) begin
        base_q   <= addr;
        op_rd_q  <= rw_n;
        has_op_q <= 1'b1;
        busy2_q  <= !len_n;
        nxt_q    <= 2'd2;
      end else if (is_cont) begin
        nxt_q <= nxt_q + 2'd2;
      end else if (is_nop) begin
        has_op_q <= 1'b0;
      end
    end
  end

  assign rdata_r = dq_oe ? q_r : '0;
  assign rdata_f = dq_oe ? q_f : '0;

  AST_G_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) oe_n |=> !dq_oe); // R8
  AST_NOP_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n) (load_n && !rw_n && !busy2_q) |=> !dq_oe); // R7
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (!load_n && !rw_n && !busy2_q) |=> !dq_oe); // R6
  AST_SECOND_HALF_FROM_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy2_q) |-> $past(!load_n && !len_n)); // R2
endmodule

// File: tb/tb_ddr_burst_sram.sv
`timescale 1ns/1ps
module tb_ddr_burst_sram;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load_n = 1'b1, rw_n = 1'b0, len_n = 1'b1, oe_n = 1'b0, order_sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata_r = '0, wdata_f = '0, rdata_r, rdata_f;
  logic dq_oe;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  ddr_burst_sram #(.ADDR_W(8), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rw_n(rw_n), .len_n(len_n),
    .addr(addr), .oe_n(oe_n), .order_sel(order_sel), .wdata_r(wdata_r),
    .wdata_f(wdata_f), .rdata_r(rdata_r), .rdata_f(rdata_f), .dq_oe(dq_oe));

  typedef struct packed {
    logic ld, rw, ln, g, ord, wflag;
    logic [7:0] a, war, waf;
    logic eo;
    logic [7:0] ear, eaf;
    logic [31:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h11,8'h11,8'h12,1'b0,8'h00,8'h00,"R6"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,8'h13,8'h10,1'b0,8'h00,8'h00,"R2"},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h26,8'h26,8'h27,1'b0,8'h00,8'h00,"R4"},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,8'h99,8'h24,8'h25,1'b0,8'h00,8'h00,"R2"},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h12,8'h00,8'h00,1'b1,8'h12,8'h13,"R1"},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,8'h10,8'h11,"R3"},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,8'h12,8'h13,"R5"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,8'h00,8'h00,"R7"},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,8'h00,8'h00,"R7"},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h25,8'h00,8'h00,1'b1,8'h25,8'h24,"R4"},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h24,8'h00,8'h00,1'b1,8'h27,8'h26,"R2"},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h10,8'h00,8'h00,1'b0,8'h00,8'h00,"R8"},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h13,8'h00,8'h00,1'b1,8'h13,8'h12,"R4"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,8'h00,8'h00,"R7"},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h24,8'h00,8'h00,1'b1,8'h24,8'h25,"R2"},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h40,8'h40,8'h41,1'b0,8'h00,8'h00,"R6"},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,8'h00,8'h42,8'h43,1'b0,8'h00,8'h00,"R5"},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h42,8'h00,8'h00,1'b1,8'h42,8'h43,"R6"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,8'h40,8'h41,"R3"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,8'h00,8'h00,"R7"},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h40,8'h00,8'h00,1'b1,8'h40,8'h41,"R4"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,8'h00,8'h00,"R1"}
  };

  function automatic logic [15:0] pat(input logic [7:0] a);
    return 16'h5A00 | {8'h00, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic ld, input logic rw, input logic ln, input logic g, input logic [7:0] a);
    load_n = ld; rw_n = rw; len_n = ln; oe_n = g; addr = a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "oe in reset", {15'd0, dq_oe}, 16'd0);
    chk("R9", "lane r in reset", rdata_r, 16'd0);
    rst_n = 1'b1;
    cmd(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    chk("R9", "continue after reset", {15'd0, dq_oe}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i].ld, VEC[i].rw, VEC[i].ln, VEC[i].g, VEC[i].a);
      order_sel = VEC[i].ord;
      wdata_r = VEC[i].wflag ? pat(VEC[i].war) : 16'hDEAD;
      wdata_f = VEC[i].wflag ? pat(VEC[i].waf) : 16'hDEAD;
      @(negedge clk);
      chk(string'(VEC[i].req), $sformatf("vec%0d oe", i), {15'd0, dq_oe}, {15'd0, VEC[i].eo});
      chk(string'(VEC[i].req), $sformatf("vec%0d lane r", i), rdata_r, VEC[i].eo ? pat(VEC[i].ear) : 16'd0);
      chk(string'(VEC[i].req), $sformatf("vec%0d lane f", i), rdata_f, VEC[i].eo ? pat(VEC[i].eaf) : 16'd0);
    end

    order_sel = 1'b0;
    cmd(1'b0, 1'b1, 1'b0, 1'b0, 8'h10);
    @(negedge clk);
    chk("R1", "double read first half", rdata_r, pat(8'h10));
    rst_n = 1'b0;
    #1;
    chk("R9", "reset mid burst oe", {15'd0, dq_oe}, 16'd0);
    chk("R9", "reset mid burst lane f", rdata_f, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cmd(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    chk("R9", "continue after mid-burst reset", {15'd0, dq_oe}, 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule